// File: doc/BRIEF.md
# Stop-Mode Entry and Wake Sequencer

This block decides how a small 8-bit microcontroller goes into its two stop modes and how it comes back out of them. The CPU raises a one-cycle halt request. A configuration bit then selects one of two modes. The deep stop turns the main oscillator off and freezes the CPU and every internally clocked peripheral. The light stop keeps the oscillator running but gates the CPU and the peripherals, so that the free-running timers can still wake the chip. Going into either mode clears the interrupt-mask bit, so an interrupt that is already pending ends the stop straight away.

Leaving the deep stop always costs a 64-cycle oscillator stabilisation wait. Leaving the light stop costs that wait only when a reset ends it. An interrupt from one of the two timers resumes the CPU on the next edge. Each exit ends with a one-cycle resume strobe, and a reason bit tells the CPU whether to service the interrupt or fetch the reset vector. If the watchdog is running and the watchdog-halt option selects reset, a halt request produces a one-cycle watchdog reset pulse and the block stays in RUN.

Top module: `lp_stop_seq`

## Requirements
- R1: While `rst` is high, and after it falls until something else happens, the block sits in RUN (`state_o` = 0) with `osc_en`, `cpu_clk_en` and `per_clk_en` all 1, `imask` = 1, and `resume` = `wdg_rst` = 0.
- R2: In RUN, `halt_req` with `ahalt_en` = 0 and no watchdog trap moves the block on the next edge to the deep stop (`state_o` = 1), where `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0.
- R3: In RUN, `halt_req` with `ahalt_en` = 1 and no watchdog trap moves the block on the next edge to the light stop (`state_o` = 2), where `osc_en` = 1 and `cpu_clk_en` = `per_clk_en` = 0.
- R4: `imask` is cleared on the same edge that enters either stop mode. Outside that event, `isr_enter` sets it and `isr_return` clears it.
- R5: In the deep stop, any bit of `gen_irq`, `rtc_irq`, `arl_irq` or `ext_rst_req` moves the block on the next edge to the delay state (`state_o` = 3), where `osc_en` = 1 and `cpu_clk_en` = 0.
- R6: The delay state lasts exactly DELAY cycles (64 by default). The block then returns to RUN, and `resume` is 1 for exactly the first RUN cycle.
- R7: In the light stop only `rtc_irq` or `arl_irq` wakes the block. Either one returns it to RUN on the next edge, with `resume` = 1 and no delay. `gen_irq` has no effect there.
- R8: `ext_rst_req` in the light stop leads into the full delay state, and the block then resumes with `resume_vec` = 1.
- R9: `resume_vec` is 0 for an interrupt service and 1 for a reset-vector fetch. When a reset and an interrupt arrive together, the reset wins.
- R10: `ext_rst_req` during the delay state forces `resume_vec` to 1 and does not restart or lengthen the delay.
- R11: If an interrupt line is already high when the deep stop is entered, the deep stop lasts a single cycle before the delay state begins.
- R12: `halt_req` with `wdg_on` = 1 and `wdg_halt_rst` = 1 pulses `wdg_rst` for one cycle on the next edge, keeps the block in RUN and leaves `imask` as it was. With `wdg_halt_rst` = 0, the halt proceeds as usual.
- R13: `halt_req` has no effect outside RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | One-cycle halt request from the CPU |
| ahalt_en | input | 1 | 1 selects the light stop, 0 the deep stop |
| wdg_halt_rst | input | 1 | Option bit: 1 turns a halt with the watchdog running into a watchdog reset |
| wdg_on | input | 1 | Watchdog is enabled |
| gen_irq | input | N_IRQ | General interrupt lines |
| rtc_irq | input | 1 | Real-time-clock timer interrupt |
| arl_irq | input | 1 | Auto-reload timer interrupt |
| ext_rst_req | input | 1 | External reset request |
| isr_enter | input | 1 | CPU entered a service routine (sets the mask) |
| isr_return | input | 1 | CPU returned from a service routine (clears the mask) |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| imask | output | 1 | Interrupt-mask bit |
| resume | output | 1 | One-cycle strobe: the CPU resumes |
| resume_vec | output | 1 | Resume reason: 0 interrupt service, 1 reset vector |
| wdg_rst | output | 1 | One-cycle watchdog reset pulse |
| state_o | output | 2 | 0 RUN, 1 deep stop, 2 light stop, 3 delay |

## Verification
The bench counts the delay state cycle by cycle. A timer that is off by one would move the resume strobe one cycle early or late, and the scoreboard's strobe timing catches that. The bench also drives a reset into the middle of a delay, which exposes a design that restarts the count or keeps the interrupt reason. It drives reset and interrupt together to test the priority. It holds general interrupts high during the light stop, where a wrong wake qualifier would leave that mode. An interrupt that is already pending at halt time must end the deep stop after one cycle. The watchdog trap must leave the block in RUN with its mask unchanged.

// File: rtl/lp_stop_pkg.sv
package lp_stop_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_AHALT = 2'd2,
        ST_WAKE  = 2'd3
    } stop_state_e;

    typedef enum logic {
        VEC_IRQ = 1'b0,
        VEC_RST = 1'b1
    } resume_src_e;

    typedef struct packed {
        logic hit;
        logic by_rst;
    } wake_evt_t;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic per;
    } clk_ctl_t;

    function automatic logic halt_traps_wdg(input logic wdg_on, input logic opt);
        return wdg_on & opt;
    endfunction

    function automatic clk_ctl_t clk_ctl_for(input stop_state_e s);
        clk_ctl_t c;
        c.osc = (s != ST_HALT);
        c.cpu = (s == ST_RUN);
        c.per = (s == ST_RUN);
        return c;
    endfunction

endpackage

// File: rtl/lp_wake_qual.sv
module lp_wake_qual
    import lp_stop_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  stop_state_e       st,
    input  logic [N_IRQ-1:0]  gen_irq,
    input  logic              rtc_irq,
    input  logic              arl_irq,
    input  logic              ext_rst,
    output wake_evt_t         evt
);
    logic gen_any;
    logic tmr_any;

    generate
        if (N_IRQ > 1) begin : g_multi
            assign gen_any = |gen_irq;
        end else begin : g_single
            assign gen_any = gen_irq[0];
        end
    endgenerate

    assign tmr_any = rtc_irq | arl_irq;

    always_comb begin
        evt.by_rst = ext_rst;
        unique case (st)
            ST_HALT:  evt.hit = gen_any | tmr_any | ext_rst;
            ST_AHALT: evt.hit = tmr_any | ext_rst;
            ST_WAKE:  evt.hit = ext_rst;
            default:  evt.hit = 1'b0;
        endcase
        if (st == ST_RUN) begin
            evt.by_rst = 1'b0;
        end
    end
endmodule

// File: rtl/lp_stab_timer.sv
module lp_stab_timer #(
    parameter int DELAY = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/lp_imask_ctl.sv
module lp_imask_ctl (
    input  logic clk,
    input  logic rst,
    input  logic stop_enter,
    input  logic isr_enter,
    input  logic isr_return,
    output logic imask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            imask <= 1'b1;
        end else if (stop_enter) begin
            imask <= 1'b0;
        end else if (isr_enter) begin
            imask <= 1'b1;
        end else if (isr_return) begin
            imask <= 1'b0;
        end
    end
endmodule

// File: rtl/lp_stop_seq.sv
module lp_stop_seq
    import lp_stop_pkg::*;
#(
    parameter int N_IRQ = 4,
    parameter int DELAY = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt_req,
    input  logic             ahalt_en,
    input  logic             wdg_halt_rst,
    input  logic             wdg_on,
    input  logic [N_IRQ-1:0] gen_irq,
    input  logic             rtc_irq,
    input  logic             arl_irq,
    input  logic             ext_rst_req,
    input  logic             isr_enter,
    input  logic             isr_return,
    output logic             osc_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             imask,
    output logic             resume,
    output logic             resume_vec,
    output logic             wdg_rst,
    output logic [1:0]       state_o
);
    stop_state_e st_q, st_d;
    resume_src_e vec_q, vec_d;
    logic        res_q, res_d;
    logic        wdg_q, wdg_d;
    logic        stop_enter;
    logic        tmr_clr;
    logic        tmr_done;
    wake_evt_t   evt;
    clk_ctl_t    gates;

    lp_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
        .st      (st_q),
        .gen_irq (gen_irq),
        .rtc_irq (rtc_irq),
        .arl_irq (arl_irq),
        .ext_rst (ext_rst_req),
        .evt     (evt)
    );

    lp_stab_timer #(.DELAY(DELAY)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clr),
        .run   (st_q == ST_WAKE),
        .done  (tmr_done)
    );

    lp_imask_ctl u_mask (
        .clk        (clk),
        .rst        (rst),
        .stop_enter (stop_enter),
        .isr_enter  (isr_enter),
        .isr_return (isr_return),
        .imask      (imask)
    );

    always_comb begin
        st_d       = st_q;
        vec_d      = vec_q;
        res_d      = 1'b0;
        wdg_d      = 1'b0;
        stop_enter = 1'b0;
        tmr_clr    = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (halt_req) begin
                    if (halt_traps_wdg(wdg_on, wdg_halt_rst)) begin
                        wdg_d = 1'b1;
                    end else begin
                        stop_enter = 1'b1;
                        st_d       = ahalt_en ? ST_AHALT : ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                if (evt.hit) begin
                    st_d    = ST_WAKE;
                    tmr_clr = 1'b1;
                    vec_d   = evt.by_rst ? VEC_RST : VEC_IRQ;
                end
            end
            ST_AHALT: begin
                if (evt.hit) begin
                    if (evt.by_rst) begin
                        st_d    = ST_WAKE;
                        tmr_clr = 1'b1;
                        vec_d   = VEC_RST;
                    end else begin
                        st_d  = ST_RUN;
                        res_d = 1'b1;
                        vec_d = VEC_IRQ;
                    end
                end
            end
            ST_WAKE: begin
                if (evt.by_rst) begin
                    vec_d = VEC_RST;
                end
                if (tmr_done) begin
                    st_d  = ST_RUN;
                    res_d = 1'b1;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            vec_q <= VEC_IRQ;
            res_q <= 1'b0;
            wdg_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            vec_q <= vec_d;
            res_q <= res_d;
            wdg_q <= wdg_d;
        end
    end

    assign gates      = clk_ctl_for(st_q);
    assign osc_en     = gates.osc;
    assign cpu_clk_en = gates.cpu;
    assign per_clk_en = gates.per;
    assign resume     = res_q;
    assign resume_vec = vec_q;
    assign wdg_rst    = wdg_q;
    assign state_o    = st_q;
endmodule

// File: rtl/lp_stop_seq_chk.sv
module lp_stop_seq_chk
    import lp_stop_pkg::*;
#(
    parameter int DELAY = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       halt_req,
    input logic       wdg_on,
    input logic       wdg_halt_rst,
    input logic       rtc_irq,
    input logic       arl_irq,
    input logic       ext_rst_req,
    input logic       imask,
    input logic       resume,
    input logic       resume_vec,
    input logic       wdg_rst,
    input logic [1:0] state_o
);
    localparam int KW = $clog2(DELAY + 2);
    logic [KW-1:0] wk_cnt;

    always_ff @(posedge clk) begin
        if (rst || state_o != ST_WAKE) begin
            wk_cnt <= '0;
        end else begin
            wk_cnt <= wk_cnt + 1'b1;
        end
    end

    // R4
    mask_clear_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RUN && halt_req && !(wdg_on && wdg_halt_rst))
        |=> (imask == 1'b0 && state_o != ST_RUN));

    // R12
    wdg_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RUN && halt_req && wdg_on && wdg_halt_rst)
        |=> (wdg_rst && state_o == ST_RUN && $stable(imask)));

    // R7
    ahalt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_AHALT && !rtc_irq && !arl_irq && !ext_rst_req)
        |=> (state_o == ST_AHALT));

    // R6
    resume_single_chk: assert property (@(posedge clk) disable iff (rst)
        resume |=> !resume);

    // R6
    delay_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_o) == ST_WAKE && state_o != ST_WAKE)
        |-> (wk_cnt == KW'(DELAY) && resume));

    // R10
    rst_in_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_WAKE && ext_rst_req) |=> resume_vec);

    // R13
    halt_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_HALT && halt_req && !ext_rst_req && !rtc_irq && !arl_irq)
        |=> (state_o != ST_RUN && !wdg_rst));
endmodule

bind lp_stop_seq lp_stop_seq_chk #(.DELAY(DELAY)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .halt_req     (halt_req),
    .wdg_on       (wdg_on),
    .wdg_halt_rst (wdg_halt_rst),
    .rtc_irq      (rtc_irq),
    .arl_irq      (arl_irq),
    .ext_rst_req  (ext_rst_req),
    .imask        (imask),
    .resume       (resume),
    .resume_vec   (resume_vec),
    .wdg_rst      (wdg_rst),
    .state_o      (state_o)
);

// File: tb/test_lp_stop_seq.sv
module test_lp_stop_seq;
    localparam int N_IRQ = 4;
    localparam int DELAY = 64;
    localparam int EV_IRQ = 0;
    localparam int EV_RST = 1;
    localparam int EV_WDG = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req = 0, ahalt_en = 0, wdg_halt_rst = 0, wdg_on = 0;
    logic [N_IRQ-1:0] gen_irq = '0;
    logic rtc_irq = 0, arl_irq = 0, ext_rst_req = 0, isr_enter = 0, isr_return = 0;
    logic osc_en, cpu_clk_en, per_clk_en, imask, resume, resume_vec, wdg_rst;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    lp_stop_seq #(.N_IRQ(N_IRQ), .DELAY(DELAY)) i_lp_stop_seq (
        .clk(clk), .rst(rst), .halt_req(halt_req), .ahalt_en(ahalt_en),
        .wdg_halt_rst(wdg_halt_rst), .wdg_on(wdg_on), .gen_irq(gen_irq),
        .rtc_irq(rtc_irq), .arl_irq(arl_irq), .ext_rst_req(ext_rst_req),
        .isr_enter(isr_enter), .isr_return(isr_return), .osc_en(osc_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .imask(imask),
        .resume(resume), .resume_vec(resume_vec), .wdg_rst(wdg_rst),
        .state_o(state_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input int code);
        exp_q.push_back(code);
    endtask

    // monitor: pops one expected event per strobe
    always @(negedge clk) begin
        if (!rst && (resume || wdg_rst)) begin
            int act;
            act = wdg_rst ? EV_WDG : (resume_vec ? EV_RST : EV_IRQ);
            if (exp_q.size() == 0) begin
                chk(1'b0, wdg_rst ? "R12 unexpected wdg pulse" : "R6 unexpected resume", act, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(act == e, (e == EV_WDG) ? "R12 event" : "R9 resume reason", act, e);
            end
        end
    end

    task automatic halt(input logic light);
        @(negedge clk);
        ahalt_en = light;
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
    endtask

    // called right after the first delay-state cycle was observed
    task automatic run_delay(input int rst_at, input string tag);
        for (int k = 2; k <= DELAY; k++) begin
            @(negedge clk);
            ext_rst_req = (k == rst_at);
            if (k == DELAY) chk(state_o == 2'd3, {tag, " still delaying"}, state_o, 3);
        end
        @(negedge clk);
        ext_rst_req = 1'b0;
        chk(state_o == 2'd0 && cpu_clk_en, {tag, " back to RUN after delay"}, state_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(state_o == 0 && osc_en && cpu_clk_en && per_clk_en, "R1 run state", state_o, 0);
        chk(imask == 1 && !resume && !wdg_rst, "R1 mask set", imask, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(state_o == 0 && imask == 1, "R1 after release", state_o, 0);

        // R4 mask handshakes
        isr_return = 1; @(negedge clk); isr_return = 0;
        chk(imask == 0, "R4 isr_return clears", imask, 0);
        isr_enter = 1; @(negedge clk); isr_enter = 0;
        chk(imask == 1, "R4 isr_enter sets", imask, 1);

        // R2 deep stop
        halt(1'b0);
        chk(state_o == 1, "R2 deep stop", state_o, 1);
        chk({osc_en, cpu_clk_en, per_clk_en} == 3'b000, "R2 all gated", {osc_en, cpu_clk_en, per_clk_en}, 0);
        chk(imask == 0, "R4 cleared on deep stop", imask, 0);
        // R13 halt_req in stop ignored
        halt_req = 1; @(negedge clk); halt_req = 0;
        @(negedge clk);
        chk(state_o == 1, "R13 halt ignored in stop", state_o, 1);

        // R5 R6 general irq wakes deep stop
        gen_irq[2] = 1'b1;
        expect_ev(EV_IRQ);
        @(negedge clk); gen_irq = '0;
        chk(state_o == 3 && osc_en && !cpu_clk_en, "R5 delay state", state_o, 3);
        run_delay(0, "R6");

        // R3 R7 light stop, general irq ignored, rtc wakes
        isr_enter = 1; @(negedge clk); isr_enter = 0;
        halt(1'b1);
        chk(state_o == 2 && osc_en && !cpu_clk_en && !per_clk_en, "R3 light stop", state_o, 2);
        chk(imask == 0, "R4 cleared on light stop", imask, 0);
        gen_irq = 4'b1011;
        repeat (3) @(negedge clk);
        chk(state_o == 2, "R7 general irq ignored", state_o, 2);
        gen_irq = '0;
        rtc_irq = 1;
        expect_ev(EV_IRQ);
        @(negedge clk); rtc_irq = 0;
        chk(state_o == 0 && resume, "R7 rtc fast wake", state_o, 0);

        // R7 auto-reload timer
        halt(1'b1);
        arl_irq = 1;
        expect_ev(EV_IRQ);
        @(negedge clk); arl_irq = 0;
        chk(state_o == 0 && resume, "R7 arl fast wake", state_o, 0);

        // R8 reset from light stop goes through delay
        halt(1'b1);
        ext_rst_req = 1;
        expect_ev(EV_RST);
        @(negedge clk); ext_rst_req = 0;
        chk(state_o == 3, "R8 light stop reset delays", state_o, 3);
        run_delay(0, "R8");
        chk(resume_vec == 1, "R8 reset vector", resume_vec, 1);

        // R9 reset and irq together
        halt(1'b0);
        ext_rst_req = 1; gen_irq[0] = 1;
        expect_ev(EV_RST);
        @(negedge clk); ext_rst_req = 0; gen_irq = '0;
        chk(state_o == 3, "R9 delay entered", state_o, 3);
        run_delay(0, "R9");

        // R10 reset during delay
        halt(1'b0);
        gen_irq[1] = 1;
        expect_ev(EV_RST);
        @(negedge clk); gen_irq = '0;
        chk(state_o == 3 && resume_vec == 0, "R10 irq reason first", resume_vec, 0);
        run_delay(10, "R10");

        // R11 pending irq at entry
        gen_irq[3] = 1;
        halt(1'b0);
        chk(state_o == 1, "R11 deep stop entered", state_o, 1);
        expect_ev(EV_IRQ);
        @(negedge clk); gen_irq = '0;
        chk(state_o == 3, "R11 one-cycle stop", state_o, 3);
        run_delay(0, "R11");

        // R12 watchdog trap
        isr_enter = 1; @(negedge clk); isr_enter = 0;
        wdg_on = 1; wdg_halt_rst = 1;
        expect_ev(EV_WDG);
        halt(1'b0);
        chk(state_o == 0 && wdg_rst && imask == 1, "R12 trap stays in RUN", state_o, 0);
        @(negedge clk);
        chk(!wdg_rst, "R12 pulse one cycle", wdg_rst, 0);
        wdg_halt_rst = 0;
        halt(1'b0);
        chk(state_o == 1 && !wdg_rst, "R12 option off halts", state_o, 1);
        rtc_irq = 1;
        expect_ev(EV_IRQ);
        @(negedge clk); rtc_irq = 0;
        run_delay(0, "R12");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all events seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule